// File: doc/BRIEF.md
# Legacy Window Memory Router

This block sits inside a host bridge and decides, for every access that falls in the top 384 KiB of the first megabyte, whether system DRAM or the PCI bus should answer. It holds seven attribute bytes and one SMRAM control byte in configuration space. The attribute bytes give thirteen legacy regions independent read and write targets. The control byte governs who can see the 128 KiB SMRAM window, and the answer differs for accesses made in System Management Mode and for ordinary ones.

Configuration traffic arrives as dword-addressed writes with byte enables, and reads are combinational. Routing requests come in with a valid strobe, an address, a write flag and an SMM flag. The result appears exactly one cycle later with its own valid strobe. The access path has no ready signal and never applies back-pressure: a request is accepted on every cycle that `req_valid` is high, and the consumer must take `rsp_*` in the cycle it is presented. A configuration change affects every request sampled after the clock edge that stores the write. A request sampled on that same edge still sees the old setting.

Top module: `legacy_window_router`

## Requirements
- R1: After reset, all attribute bytes read 0x00 and the SMRAM byte at offset 0x72 reads 0x02. Every claimed non-SMM access then routes to PCI, and so does every SMM access to the SMRAM window.
- R2: Configuration accesses use a byte offset `cfg_addr`. Bits [1:0] are ignored and byte lane j of `cfg_wdata`/`cfg_rdata` holds offset {cfg_addr[7:2], j}. Only bytes whose enable is set change. The attribute bytes live at 0x59 to 0x5F and the SMRAM byte at 0x72. Any other offset reads 0 and ignores writes.
- R3: A region attribute is a 2-bit field. Bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM, so 00 routes everything to PCI and 11 routes everything to DRAM. Fields sit in bits [1:0] (low nibble) and [5:4] (high nibble) of an attribute byte. All other attribute bits read 0, and so does the low nibble of 0x59.
- R4: Region 0 covers 0xF0000 to 0xFFFFF and uses the high nibble of 0x59. Region k, for k from 1 to 12, covers the 16 KiB block starting at 0xC0000 + (k-1)*0x4000. It uses byte 0x59 + (k+1)/2, taking the low nibble when k is odd and the high nibble when k is even.
- R5: A non-SMM access to 0xA0000 to 0xBFFFF goes to DRAM exactly when bit 6 (open) of the SMRAM byte is set.
- R6: An SMM access to 0xA0000 to 0xBFFFF goes to DRAM when bit 3 (global enable) or bit 6 (open) is set, and to PCI otherwise.
- R7: Bit 4 (lock) of the SMRAM byte can only be set, and it clears only on reset. While lock is set, the open bit reads 0 and writes to it are ignored, including a write that sets lock and open together. Bits [2:0] always read 010, and bits 7 and 5 read 0.
- R8: Addresses below 0xA0000 or above 0xFFFFF are not claimed: `rsp_claim` and `rsp_dram` are both 0. Every address from 0xA0000 to 0xFFFFF is claimed.
- R9: `rsp_valid` equals `req_valid` delayed by one cycle, and the response reflects the configuration as it stood when the request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (dword aligned use) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data, lane j for offset {addr[7:2], j} |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| req_valid | input | 1 | Routing request present |
| req_addr | input | ADDR_W | Physical address of the access |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_smm | input | 1 | 1 = access made in System Management Mode |
| rsp_valid | output | 1 | Routing result present |
| rsp_claim | output | 1 | Address lies in the decoded legacy span |
| rsp_dram | output | 1 | 1 = DRAM responds, 0 = PCI responds |

## Verification
On every cycle the assertions check the lock rules: lock stays set and keeps open at 0. They also check that attribute and control bytes hold still without a write, that at most one window matches an address, that unclaimed results never point at DRAM, and that a closed SMRAM window never sends a non-SMM access to DRAM. The bench's scenarios are the only check on the values themselves: the nibble-to-region assignment at each region's edges, the read/write split of each attribute code, byte-enable masking and ignored offsets. They also cover the ordering between a configuration write and a request sampled on the same edge.

// File: rtl/lwr_pkg.sv
package lwr_pkg;

  // Decoded legacy regions: one top block plus twelve expansion blocks.
  localparam int NUM_REGIONS = 13;
  localparam int ATTR_BYTES  = 7;

  // Configuration offsets the routing depends on.
  localparam logic [7:0] ATTR_BASE  = 8'h59;
  localparam logic [7:0] SMRAM_OFF  = 8'h72;

  // SMRAM control byte bit positions.
  localparam int OPEN_BIT = 6;
  localparam int LOCK_BIT = 4;
  localparam int GEN_BIT  = 3;
  localparam logic [2:0] SMRAM_FIXED = 3'b010;

  // Writable bits of an attribute byte (two 2-bit fields).
  localparam logic [7:0] ATTR_MASK      = 8'h33;
  localparam logic [7:0] ATTR_MASK_TOP  = 8'h30;

  typedef logic [1:0] attr_t;

  typedef struct packed {
    logic open;
    logic lock;
    logic gen;
  } smram_ctl_t;

  // Which attribute byte serves region k.
  function automatic int attr_byte_of(input int k);
    return (k + 1) / 2;
  endfunction

  // Bit offset of region k's field inside its byte.
  function automatic int attr_shift_of(input int k);
    return ((k == 0) || (k % 2 == 0)) ? 4 : 0;
  endfunction

  function automatic logic [7:0] smram_byte(input smram_ctl_t c);
    return {1'b0, c.open, 1'b0, c.lock, c.gen, SMRAM_FIXED};
  endfunction

endpackage

// File: rtl/lwr_cfg_regs.sv
module lwr_cfg_regs
  import lwr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_addr,
  input  logic [3:0]              cfg_be,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  output logic [8*ATTR_BYTES-1:0] attr_flat,
  output smram_ctl_t              smram_ctl
);

  localparam int SM_LANE = int'(SMRAM_OFF[1:0]);

  // Attribute byte storage, one register per byte.
  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
    localparam logic [7:0] BADDR = ATTR_BASE + 8'(b);
    localparam int         LANE  = int'(BADDR[1:0]);
    localparam logic [7:0] MASK  = (b == 0) ? ATTR_MASK_TOP : ATTR_MASK;
    logic       hit;
    logic [7:0] q;

    assign hit = cfg_we && (cfg_addr[7:2] == BADDR[7:2]) && cfg_be[LANE];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= cfg_wdata[8*LANE +: 8] & MASK;
      end
    end

    assign attr_flat[8*b +: 8] = q;
  end

  // SMRAM control byte with sticky lock.
  logic       sm_hit;
  logic [7:0] sm_wbyte;
  logic       lock_n;
  smram_ctl_t ctl_q;

  assign sm_hit   = cfg_we && (cfg_addr[7:2] == SMRAM_OFF[7:2]) && cfg_be[SM_LANE];
  assign sm_wbyte = cfg_wdata[8*SM_LANE +: 8];
  assign lock_n   = ctl_q.lock | sm_wbyte[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '{open: 1'b0, lock: 1'b0, gen: 1'b0};
    end else if (sm_hit) begin
      ctl_q.lock <= lock_n;
      ctl_q.open <= lock_n ? 1'b0 : sm_wbyte[OPEN_BIT];
      ctl_q.gen  <= sm_wbyte[GEN_BIT];
    end
  end

  assign smram_ctl = ctl_q;

  // Combinational readback, one lane at a time.
  always_comb begin
    cfg_rdata = '0;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] ba;
      int         idx;
      ba  = {cfg_addr[7:2], 2'(j)};
      idx = int'(ba) - int'(ATTR_BASE);
      if (idx >= 0 && idx < ATTR_BYTES) begin
        cfg_rdata[8*j +: 8] = attr_flat[8*idx +: 8];
      end else if (ba == SMRAM_OFF) begin
        cfg_rdata[8*j +: 8] = smram_byte(ctl_q);
      end
    end
  end

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> ctl_q.lock);

  // R7
  lock_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.lock |=> !ctl_q.open);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(attr_flat) && $stable(ctl_q)));

endmodule

// File: rtl/lwr_region_decode.sv
module lwr_region_decode
  import lwr_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int unsigned TOP_BASE   = 32'h000F_0000,
  parameter int unsigned TOP_SIZE   = 32'h0001_0000,
  parameter int unsigned EXP_BASE   = 32'h000C_0000,
  parameter int unsigned EXP_SIZE   = 32'h0000_4000,
  parameter int unsigned SMRAM_BASE = 32'h000A_0000,
  parameter int unsigned SMRAM_SIZE = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_REGIONS-1:0] region_hit,
  output logic                   smram_hit
);

  localparam int XW = ADDR_W + 1;
  logic [XW-1:0] ax;

  assign ax = {1'b0, addr};

  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_reg
    localparam longint unsigned LO =
      (k == 0) ? longint'(TOP_BASE) : longint'(EXP_BASE) + longint'(k - 1) * longint'(EXP_SIZE);
    localparam longint unsigned HI =
      LO + ((k == 0) ? longint'(TOP_SIZE) : longint'(EXP_SIZE));
    assign region_hit[k] = (ax >= XW'(LO)) && (ax < XW'(HI));
  end

  localparam longint unsigned SM_LO = longint'(SMRAM_BASE);
  localparam longint unsigned SM_HI = longint'(SMRAM_BASE) + longint'(SMRAM_SIZE);

  assign smram_hit = (ax >= XW'(SM_LO)) && (ax < XW'(SM_HI));

endmodule

// File: rtl/lwr_route.sv
module lwr_route
  import lwr_pkg::*;
(
  input  logic [NUM_REGIONS-1:0]  region_hit,
  input  logic                    smram_hit,
  input  logic [8*ATTR_BYTES-1:0] attr_flat,
  input  smram_ctl_t              smram_ctl,
  input  logic                    is_write,
  input  logic                    is_smm,
  output logic                    to_dram
);

  logic [NUM_REGIONS-1:0] dram_sel;
  logic                   smram_dram;

  // Per-region field extraction and read/write selection.
  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_sel
    localparam int BI = attr_byte_of(k);
    localparam int SH = attr_shift_of(k);
    attr_t fld;
    assign fld         = attr_flat[8*BI + SH +: 2];
    assign dram_sel[k] = is_write ? fld[1] : fld[0];
  end

  // SMRAM window: open exposes it to everyone, global enable to SMM only.
  always_comb begin
    if (is_smm) begin
      smram_dram = smram_ctl.gen | smram_ctl.open;
    end else begin
      smram_dram = smram_ctl.open;
    end
  end

  assign to_dram = (|(region_hit & dram_sel)) | (smram_hit & smram_dram);

endmodule

// File: rtl/legacy_window_router.sv
module legacy_window_router
  import lwr_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int unsigned TOP_BASE   = 32'h000F_0000,
  parameter int unsigned TOP_SIZE   = 32'h0001_0000,
  parameter int unsigned EXP_BASE   = 32'h000C_0000,
  parameter int unsigned EXP_SIZE   = 32'h0000_4000,
  parameter int unsigned SMRAM_BASE = 32'h000A_0000,
  parameter int unsigned SMRAM_SIZE = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic              rsp_dram
);

  logic [8*ATTR_BYTES-1:0] attr_flat;
  smram_ctl_t              smram_ctl;
  logic [NUM_REGIONS-1:0]  region_hit;
  logic                    smram_hit;
  logic                    to_dram;
  logic                    claim;

  lwr_cfg_regs i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .attr_flat (attr_flat),
    .smram_ctl (smram_ctl)
  );

  lwr_region_decode #(
    .ADDR_W     (ADDR_W),
    .TOP_BASE   (TOP_BASE),
    .TOP_SIZE   (TOP_SIZE),
    .EXP_BASE   (EXP_BASE),
    .EXP_SIZE   (EXP_SIZE),
    .SMRAM_BASE (SMRAM_BASE),
    .SMRAM_SIZE (SMRAM_SIZE)
  ) i_dec (
    .addr       (req_addr),
    .region_hit (region_hit),
    .smram_hit  (smram_hit)
  );

  lwr_route i_route (
    .region_hit (region_hit),
    .smram_hit  (smram_hit),
    .attr_flat  (attr_flat),
    .smram_ctl  (smram_ctl),
    .is_write   (req_write),
    .is_smm     (req_smm),
    .to_dram    (to_dram)
  );

  assign claim = (|region_hit) | smram_hit;

  // Registered result stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_dram  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_claim <= req_valid & claim;
      rsp_dram  <= req_valid & to_dram;
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8
  unclaimed_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_claim) |-> !rsp_dram);

  // R8
  single_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({region_hit, smram_hit}));

  // R5
  smram_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && smram_hit && !req_smm && !smram_ctl.open) |=> !rsp_dram);

endmodule

// File: tb/test_legacy_window_router.sv
module test_legacy_window_router;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [7:0]        cfg_addr;
  logic [3:0]        cfg_be;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_rdata;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_write;
  logic              req_smm;
  logic              rsp_valid;
  logic              rsp_claim;
  logic              rsp_dram;

  int tests  = 0;
  int failed = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_window_router #(.ADDR_W(ADDR_W)) i_legacy_window_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_smm   (req_smm),
    .rsp_valid (rsp_valid),
    .rsp_claim (rsp_claim),
    .rsp_dram  (rsp_dram)
  );

  // Vector: {addr, write, smm, exp_claim, exp_dram}, under the setup below.
  localparam int NV = 19;
  localparam logic [35:0] VEC [NV] = '{
    {32'h000F_0000, 4'b0011},
    {32'h000F_FFFF, 4'b1011},
    {32'h000C_0000, 4'b0011},
    {32'h000C_3FFF, 4'b1010},
    {32'h000C_4000, 4'b0010},
    {32'h000C_7FFF, 4'b1011},
    {32'h000C_8000, 4'b0010},
    {32'h000C_C000, 4'b1011},
    {32'h000D_0000, 4'b0011},
    {32'h000D_4000, 4'b0010},
    {32'h000E_8000, 4'b1010},
    {32'h000E_FFFF, 4'b1011},
    {32'h000E_C000, 4'b0010},
    {32'h000A_0000, 4'b0010},
    {32'h000B_FFFF, 4'b1111},
    {32'h000A_0000, 4'b0111},
    {32'h0009_FFFF, 4'b0000},
    {32'h0010_0000, 4'b0000},
    {32'h0000_0000, 4'b1100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  // Request presented before an edge; result sampled at the following negedge.
  task automatic access(input string tag, input logic [31:0] a, input logic w,
                        input logic s, input logic ec, input logic ed);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_smm = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " claim"}, 32'(rsp_claim), 32'(ec));
    chk({tag, " dram"},  32'(rsp_dram),  32'(ed));
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_smm = 1'b0;
    do_reset();

    // R1 reset state
    cfg_check("R1 attr 58", 8'h58, 32'h0000_0000);
    cfg_check("R1 attr 5C", 8'h5C, 32'h0000_0000);
    cfg_check("R1 smram", 8'h70, 32'h0002_0000);
    access("R1 top rd", 32'h000F_0000, 1'b0, 1'b0, 1'b1, 1'b0);
    access("R1 exp wr", 32'h000C_4000, 1'b1, 1'b0, 1'b1, 1'b0);
    access("R1 smram smm", 32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 idle valid", 32'(rsp_valid), 32'd0);

    // Setup for vector table (R2 R3 R4)
    cfg_write(8'h58, 4'b1110, 32'h3021_30FF);
    cfg_write(8'h5C, 4'b1111, 32'h2000_0003);
    cfg_write(8'h70, 4'b0100, 32'h0008_0000);
    cfg_check("R2 attr 58 readback", 8'h58, 32'h3021_3000);
    cfg_check("R2 attr 5C readback", 8'h5C, 32'h2000_0003);
    cfg_check("R7 smram gen", 8'h70, 32'h000A_0000);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] a;
      string tag;
      a = VEC[i][35:4];
      if (a < 32'h000A_0000 || a > 32'h000F_FFFF) tag = "R8";
      else if (a < 32'h000C_0000) tag = VEC[i][2] ? "R6" : "R5";
      else if (a >= 32'h000F_0000) tag = "R4";
      else tag = "R3";
      access($sformatf("%s vec%0d", tag, i), a, VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R3 byte-enable masking and unused bits
    cfg_write(8'h5C, 4'b0001, 32'hFFFF_FFFF);
    cfg_check("R3 masked 5C", 8'h5C, 32'h2000_0033);
    access("R4 region6 rd", 32'h000D_4000, 1'b0, 1'b0, 1'b1, 1'b1);
    // R2 ignored offset
    cfg_write(8'h40, 4'b1111, 32'hFFFF_FFFF);
    cfg_check("R2 unmapped", 8'h40, 32'h0000_0000);

    // R9 same-edge ordering: request sees old attribute
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h58; cfg_be = 4'b0010; cfg_wdata = 32'h0;
    req_valid = 1'b1; req_addr = 32'h000F_0000; req_write = 1'b0; req_smm = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0; req_valid = 1'b0;
    chk("R9 old config", 32'(rsp_dram), 32'd1);
    access("R9 new config", 32'h000F_0000, 1'b0, 1'b0, 1'b1, 1'b0);

    // R5 open, R6 gen
    cfg_write(8'h70, 4'b0100, 32'h0048_0000);
    cfg_check("R7 open set", 8'h70, 32'h004A_0000);
    access("R5 open rd", 32'h000A_0000, 1'b0, 1'b0, 1'b1, 1'b1);
    // R7 lock
    cfg_write(8'h70, 4'b0100, 32'h0018_0000);
    cfg_check("R7 lock set", 8'h70, 32'h001A_0000);
    access("R5 closed wr", 32'h000B_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    access("R6 gen smm", 32'h000B_0000, 1'b1, 1'b1, 1'b1, 1'b1);
    cfg_write(8'h70, 4'b0100, 32'h0045_0000);
    cfg_check("R7 open blocked", 8'h70, 32'h0012_0000);
    access("R6 no gen smm", 32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b0);

    // R7 lock cleared by reset, lock+open together
    do_reset();
    cfg_check("R1 smram after reset", 8'h70, 32'h0002_0000);
    cfg_write(8'h70, 4'b0100, 32'h0040_0000);
    cfg_check("R7 open after reset", 8'h70, 32'h0042_0000);
    do_reset();
    cfg_write(8'h70, 4'b0100, 32'h0050_0000);
    cfg_check("R7 lock with open", 8'h70, 32'h0012_0000);
    access("R5 lock closed", 32'h000A_0000, 1'b0, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule